// File: doc/BRIEF.md
# Grouped GPIO Port Bank

This block is a bank of general-purpose I/O lines arranged as groups of eight. Each group owns one byte-wide data register in I/O space. The register sits at a programmable base address plus the group index. A write to a group's register loads that group's output latches. A read returns the levels present on that group's pins, after a two-flop synchronizer. Software changes single lines by reading the group, altering one bit and writing the byte back.

Two per-line vectors from the configuration logic decide whether a pin drives. The output-enable vector has one bit per line. The simple-I/O enable vector exists only for the lowest few groups; lines in higher groups always behave as simple I/O. A pin drives its latch value when its output enable is set and its simple-I/O function is active. Otherwise it is released as an input. The bank responds only inside an eight-address window starting at the base. Any access outside that window has no effect.

Top module: `gpio_group_bank`

## Requirements
- R1: Line n belongs to group n/8 and uses bit n%8 of that group's data register, so `pin_out[8*g+b]` is bit b of the value last written to group g.
- R2: A write strobe at address base+g (g in 0..7) loads `io_wdata` into group g's latches, visible on `pin_out` one clock edge later. The other groups keep their values.
- R3: A read strobe at base+g returns on `io_rdata` the synchronized levels of group g's pins, with `io_rvalid` high for one cycle after the capturing edge. A pin change applied before clock edge k is returned by a read captured at edge k+2 or later; a read captured at edge k+1 still returns the old level.
- R4: A strobe whose address lies outside base..base+7 changes no latch and does not raise `io_rvalid`.
- R5: One edge after any change, `pin_oe[n]` equals `oe_en[n]` AND the line's simple-I/O enable. Lines in groups 0..4 use `sio_en[n]`; lines in groups 5..7 treat it as 1.
- R6: While reset is high, and after it is released, all output latches, `pin_oe`, `io_rdata` and `io_rvalid` are 0.
- R7: The window offset is address minus base modulo 2^16. With base 0xFFFC, address 0x0002 selects group 6, and address 0xFFFB is outside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_rvalid | output | 1 | Read data valid, one cycle per accepted read |
| base_addr | input | 16 | Base I/O address of group 0 |
| oe_en | input | 64 | Per-line output enable |
| sio_en | input | 40 | Per-line simple-I/O enable for groups 0..4 |
| pin_in | input | 64 | Pin levels from the pads |
| pin_out | output | 64 | Output latch values to the pads |
| pin_oe | output | 64 | Per-pin drive enable to the pads |

## Verification
Several properties are checked on every cycle. Read-valid appears only after an in-window read. Latches stay still when no in-window write occurs. A written byte lands in its group's latch. No pin drives unless its output enable was set on the previous cycle. Reset clears the latches and the drive enables. Other behaviour shows up only in the bench's scenarios: the exact synchronizer latency seen by reads, the data returned for each group under distinct pin patterns, the group-to-line mapping, the groups without simple-I/O control, and the address wrap near the top of the 16-bit space.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] gpio_byte_t;
endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode #(
  parameter int ADDR_W     = 16,
  parameter int NUM_GROUPS = 8,
  localparam int GI_W      = $clog2(NUM_GROUPS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  output logic              hit,
  output logic [GI_W-1:0]   grp
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - base;
    hit    = (offset < ADDR_W'(NUM_GROUPS));
    grp    = offset[GI_W-1:0];
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_group.sv
module gpio_group
  import gpio_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  gpio_byte_t wr_data,
  input  gpio_byte_t oe_bits,
  input  gpio_byte_t sio_bits,
  output gpio_byte_t latch_q,
  output gpio_byte_t drive_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      drive_q <= '0;
    end else begin
      if (wr_en) latch_q <= wr_data;
      drive_q <= oe_bits & sio_bits;
    end
  end

  // R2
  group_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (latch_q == $past(wr_data)));

  // R6
  group_reset_chk: assert property (@(posedge clk)
    rst |=> (latch_q == '0 && drive_q == '0));
endmodule

// File: rtl/gpio_group_bank.sv
module gpio_group_bank
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_GROUPS = 8,
  parameter int SIO_GROUPS = 5,
  localparam int GROUP_W   = BYTE_W,
  localparam int LINES     = NUM_GROUPS * GROUP_W,
  localparam int SIO_LINES = SIO_GROUPS * GROUP_W,
  localparam int GI_W      = $clog2(NUM_GROUPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [GROUP_W-1:0]   io_wdata,
  output logic [GROUP_W-1:0]   io_rdata,
  output logic                 io_rvalid,
  input  logic [ADDR_W-1:0]    base_addr,
  input  logic [LINES-1:0]     oe_en,
  input  logic [SIO_LINES-1:0] sio_en,
  input  logic [LINES-1:0]     pin_in,
  output logic [LINES-1:0]     pin_out,
  output logic [LINES-1:0]     pin_oe
);
  logic            win_hit;
  logic [GI_W-1:0] win_grp;
  logic [LINES-1:0] pin_sync;
  logic            wr_hit;
  logic            rd_hit;

  gpio_win_decode #(.ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS)) u_dec (
    .addr (io_addr),
    .base (base_addr),
    .hit  (win_hit),
    .grp  (win_grp)
  );

  gpio_sync2 #(.W(LINES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  assign wr_hit = io_wr && win_hit;
  assign rd_hit = io_rd && win_hit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    gpio_byte_t sio_eff;
    if (g < SIO_GROUPS) begin : g_sio
      assign sio_eff = sio_en[g*GROUP_W +: GROUP_W];
    end else begin : g_nosio
      assign sio_eff = '1;
    end

    gpio_group u_grp (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_hit && (win_grp == GI_W'(g))),
      .wr_data  (io_wdata),
      .oe_bits  (oe_en[g*GROUP_W +: GROUP_W]),
      .sio_bits (sio_eff),
      .latch_q  (pin_out[g*GROUP_W +: GROUP_W]),
      .drive_q  (pin_oe[g*GROUP_W +: GROUP_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata  <= '0;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= rd_hit;
      if (rd_hit) io_rdata <= pin_sync[int'(win_grp)*GROUP_W +: GROUP_W];
    end
  end

  // R4
  rvalid_window_chk: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(io_rd && win_hit));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(pin_out));

  // R5
  drive_needs_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 ((pin_oe & ~$past(oe_en)) == '0));
endmodule

// File: tb/tb_gpio_group_bank.sv
module tb_gpio_group_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic [15:0] base_addr = 16'h0A00;
  logic [63:0] oe_en = '0;
  logic [39:0] sio_en = '0;
  logic [63:0] pin_in = '0;
  logic [63:0] pin_out;
  logic [63:0] pin_oe;

  int tests = 0;
  int fails = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [63:0] model_lat = '0;

  always #10 clk = ~clk;

  gpio_group_bank dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
    .base_addr(base_addr), .oe_en(oe_en), .sio_en(sio_en), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected byte per read-valid
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R4: actual rvalid=1 expected rvalid=0 (no read pending)");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (io_rdata !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] off;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    off = a - base_addr;
    if (off < 16'd8) model_lat[off[2:0]*8 +: 8] = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] pat;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 pin_out", pin_out, '0);
    chk("R6 pin_oe", pin_oe, '0);
    chk("R6 rvalid", {63'd0, io_rvalid}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R6 after release", pin_out | pin_oe, '0);
    chk("R6 rdata", {56'd0, io_rdata}, '0);

    // R2 write all groups
    for (int g = 0; g < 8; g++) io_write(16'h0A00 + 16'(g), 8'(8'h3C ^ (g * 37)));
    chk("R2 all groups", pin_out, model_lat);
    // R1 mapping: line 29 is group 3 bit 5
    chk("R1 line29", {63'd0, pin_out[29]}, {63'd0, model_lat[29]});
    io_write(16'h0A03, 8'h20);
    chk("R1 line29 set only", pin_out[31:24], 8'h20);
    io_write(16'h0A02, 8'hFF);
    chk("R2 neighbours kept", pin_out, model_lat);

    // R3 reads of pin levels
    pat = 64'h0123_4567_89AB_CDEF;
    @(negedge clk); pin_in = pat;
    repeat (3) @(negedge clk);
    for (int g = 0; g < 8; g++) io_read(16'h0A00 + 16'(g), pat[g*8 +: 8], "R3 pattern A");
    pat = 64'hF0E1_D2C3_B4A5_9687;
    @(negedge clk); pin_in = pat;
    repeat (3) @(negedge clk);
    for (int g = 7; g >= 0; g--) io_read(16'h0A00 + 16'(g), pat[g*8 +: 8], "R3 pattern B");

    // R3 synchronizer latency
    @(negedge clk);
    pin_in[7:0] = 8'h5A; // applied before edge k
    @(negedge clk);      // edge k passed
    io_addr = 16'h0A00; io_rd = 1'b1;
    exp_q.push_back(pat[7:0]); tag_q.push_back("R3 capture at k+1 old");
    @(negedge clk);      // captured at k+1
    exp_q.push_back(8'h5A); tag_q.push_back("R3 capture at k+2 new");
    @(negedge clk);      // captured at k+2
    io_rd = 1'b0;

    // R4 outside window
    pat = pin_out;
    io_write(16'h0A08, 8'h99);
    io_write(16'h09FF, 8'h77);
    chk("R4 no latch change", pin_out, pat);
    @(negedge clk); io_addr = 16'h0A08; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    chk("R4 no rvalid", {63'd0, io_rvalid}, '0);

    // R7 wrap around 16-bit space
    base_addr = 16'hFFFC;
    io_write(16'h0002, 8'hC3);
    chk("R7 wrap selects group6", {56'd0, pin_out[55:48]}, 64'hC3);
    pat = pin_out;
    io_write(16'hFFFB, 8'h11);
    chk("R7 below base ignored", pin_out, pat);

    // R5 drive enables
    @(negedge clk); oe_en = '1; sio_en = '0;
    @(negedge clk);
    chk("R5 groups without sio", pin_oe, 64'hFFFFFF00_00000000);
    oe_en = 64'h1234_5678_9ABC_DEF0; sio_en = '1;
    @(negedge clk);
    chk("R5 oe passes", pin_oe, 64'h1234_5678_9ABC_DEF0);
    sio_en = 40'h00_FF00_F00F;
    @(negedge clk);
    chk("R5 mixed sio", pin_oe, 64'h1234_5600_9A00_D000);
    oe_en = '0;
    @(negedge clk);
    chk("R5 oe cleared", pin_oe, '0);

    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", 64'(exp_q.size()), '0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule